// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one capture/compare channel that sits next to a free-running timer counter. It does not own the counter; it receives the count value and an update strobe, which marks counter overflow. A small register port lets software set the channel's mode and read or write its value. The channel holds two value registers. The bus register is the only one that software can reach. A second, working register faces the counter.

In compare mode, the working register is loaded from the bus register. With buffering on, the load waits for the next update strobe. With buffering off, the load happens on the same clock as the bus write. The working register is compared to the counter, and the result is given as two signals, "equal" and "greater than", for a downstream waveform stage. In capture mode, the input pin is synchronised and its selected edge is detected. The counter is then snapshotted into the working register, and on the following clock the snapshot is moved into the bus register. Every capture, and every arrival of a compare match, raises an event flag. The flag can drive an interrupt line and a one-cycle DMA request.

Top module: `capcmp_channel`

## Requirements
- R1: After reset, every readable register reads 0 and `irq` and `dma_req` are low.
- R2: Bus address 2 reads and writes the bus-side value register. The working register has no bus address, and address 3 reads 0.
- R3: In compare mode (control bit 0 = 0) with buffering off (control bit 2 = 0), a write to address 2 changes the compare result from the next clock edge.
- R4: In compare mode with buffering on (control bit 2 = 1), the working register keeps its value until a clock on which `upd_evt` is high. It then takes the bus-side value.
- R5: In compare mode, `cmp_eq` is high when `cnt` equals the working register and `cmp_gt` is high when `cnt` is greater (unsigned). Both are low in capture mode, and the two are never high together.
- R6: In compare mode, the event flag (status bit 0, address 1) is set on the clock edge that ends the first cycle of a match. `irq` equals the flag ANDed with control bit 3.
- R7: In capture mode (control bit 0 = 1), an edge on `sig_in` passes through a two-stage synchroniser. The `cnt` present during the third clock after the pin change is stored. On the fourth clock the value appears at address 2 and the event flag sets.
- R8: Control bit 1 selects the capture edge: 0 means rising, 1 means falling. The other edge captures nothing.
- R9: A capture that completes while the event flag is already set sets the overcapture flag (status bit 1). The newer value replaces the old one at address 2.
- R10: Writing a status bit as 0 clears it and writing it as 1 leaves it unchanged. A new event on the same clock wins over the clear.
- R11: With control bit 4 set, every flag-setting event produces a `dma_req` pulse exactly one cycle long, on the same edge on which the flag sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt | input | CW | Timer counter value |
| upd_evt | input | 1 | Update strobe (counter overflow) |
| sig_in | input | 1 | Asynchronous capture input |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 value |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Read data (combinational) |
| cmp_eq | output | 1 | Counter equals compare value |
| cmp_gt | output | 1 | Counter greater than compare value |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | One-cycle DMA request |

## Verification
The checker runs on every cycle. It checks that equal and greater-than are mutually exclusive, and that the working register holds steady under buffering until an update arrives. It checks that a compare flag only rises after a match, that overcapture only rises while the flag was set, and that DMA requests never last two cycles. Some behaviour can only be shown by the bench scenarios: the exact capture latency and which counter sample is taken, the effect of edge polarity, the clear-by-zero semantics, and the compare results across boundary values such as zero and all-ones.

// File: rtl/capcmp_channel.sv
`timescale 1ns/1ps
module capcmp_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          upd_evt,
  input  logic          sig_in,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          cmp_eq,
  output logic          cmp_gt,
  output logic          irq,
  output logic          dma_req
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_VAL  = 2'd2;
  localparam int CTRL_W = 5;

  logic [CTRL_W-1:0] ctrl;
  logic [CW-1:0]     pre, shd;
  logic [2:0]        sync;
  logic              flag, ovr, eq_d, cap_d;

  wire cap_mode = ctrl[0];
  wire fall_sel = ctrl[1];
  wire pre_en   = ctrl[2];
  wire irq_en   = ctrl[3];
  wire dma_en   = ctrl[4];

  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire wr_stat = bus_wr && bus_addr == A_STAT;
  wire wr_val  = bus_wr && bus_addr == A_VAL;

  wire edge_r  = sync[1] & ~sync[2];
  wire edge_f  = ~sync[1] & sync[2];
  wire cap     = cap_mode & (fall_sel ? edge_f : edge_r);
  wire cmp_hit = ~cap_mode & cmp_eq & ~eq_d;
  wire set_evt = cap_d | cmp_hit;

  assign cmp_eq = !cap_mode && cnt == shd;
  assign cmp_gt = !cap_mode && cnt > shd;
  assign irq    = flag & irq_en;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl;
      A_STAT:  bus_rdata[1:0] = {ovr, flag};
      A_VAL:   bus_rdata = pre;
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      pre     <= '0;
      shd     <= '0;
      sync    <= '0;
      flag    <= 1'b0;
      ovr     <= 1'b0;
      eq_d    <= 1'b0;
      cap_d   <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      sync    <= {sync[1:0], sig_in};
      eq_d    <= cmp_eq;
      cap_d   <= cap;
      dma_req <= set_evt & dma_en;
      if (wr_ctrl) ctrl <= bus_wdata[CTRL_W-1:0];
      flag <= set_evt | (flag & ~(wr_stat & ~bus_wdata[0]));
      ovr  <= (cap_d & flag) | (ovr & ~(wr_stat & ~bus_wdata[1]));
      if (cap_d)       pre <= shd;
      else if (wr_val) pre <= bus_wdata;
      if (cap_mode) begin
        if (cap) shd <= cnt;
      end else if (pre_en) begin
        if (upd_evt) shd <= pre;
      end else if (wr_val) begin
        shd <= bus_wdata;
      end
    end
  end
endmodule

// File: rtl/capcmp_channel_chk.sv
`timescale 1ns/1ps
module capcmp_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cap_mode,
  input logic          pre_en,
  input logic          upd_evt,
  input logic [CW-1:0] shd,
  input logic          flag,
  input logic          ovr,
  input logic          cmp_eq,
  input logic          cmp_gt,
  input logic          dma_req
);
  AST_EQ_GT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmp_eq && cmp_gt)); // R5
  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_mode && pre_en && !upd_evt) |=> $stable(shd)); // R4
  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_mode && !$past(cap_mode) && $rose(flag)) |-> $past(cmp_eq)); // R6
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(flag)); // R9
  AST_DMA_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req); // R11
endmodule

bind capcmp_channel capcmp_channel_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_mode(cap_mode), .pre_en(pre_en),
  .upd_evt(upd_evt), .shd(shd), .flag(flag), .ovr(ovr),
  .cmp_eq(cmp_eq), .cmp_gt(cmp_gt), .dma_req(dma_req)
);

// File: tb/capcmp_channel_bench.sv
`timescale 1ns/1ps
module capcmp_channel_bench;
  localparam int CW = 16;
  logic clk = 0, rst_n = 0, upd_evt = 0, sig_in = 0, bus_wr = 0;
  logic [CW-1:0] cnt = 16'd5, bus_wdata = '0, bus_rdata;
  logic [1:0] bus_addr = '0;
  logic cmp_eq, cmp_gt, irq, dma_req;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  capcmp_channel #(.CW(CW)) u_capcmp_channel (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .upd_evt(upd_evt), .sig_in(sig_in),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cmp_eq(cmp_eq), .cmp_gt(cmp_gt),
    .irq(irq), .dma_req(dma_req)
  );

  // value, counter, expected eq, expected gt
  localparam logic [33:0] TBL [7] = '{
    {16'd10,    16'd10,    1'b1, 1'b0},
    {16'd10,    16'd9,     1'b0, 1'b0},
    {16'd10,    16'd11,    1'b0, 1'b1},
    {16'd0,     16'd0,     1'b1, 1'b0},
    {16'hFFFF,  16'hFFFF,  1'b1, 1'b0},
    {16'hFFFF,  16'd0,     1'b0, 1'b0},
    {16'd0,     16'hFFFF,  1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [CW-1:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] r;
    cycles(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(A(0), r); chk("R1 ctrl", r, 0);
    rd(A(1), r); chk("R1 stat", r, 0);
    rd(A(2), r); chk("R1 val", r, 0);
    chk("R1 irq", irq, 0);
    chk("R1 dma", dma_req, 0);
    rd(A(3), r); chk("R2 addr3 reads zero", r, 0);

    // R3 R5 table walk, compare mode, no buffering
    wr(2'd0, 16'h0000);
    for (int k = 0; k < 7; k++) begin
      wr(2'd2, TBL[k][33:18]);
      cnt = TBL[k][17:2];
      #1;
      chk("R3 R5 cmp_eq", cmp_eq, TBL[k][1]);
      chk("R5 cmp_gt", cmp_gt, TBL[k][0]);
      @(negedge clk);
    end
    wr(2'd1, 16'h0000);

    // R2 R4 buffered compare
    cnt = 16'd100;
    wr(2'd0, 16'h0004);
    wr(2'd2, 16'd100);
    rd(A(2), r); chk("R2 value readback", r, 100);
    cycles(2);
    chk("R4 shadow held without update", cmp_eq, 0);
    @(negedge clk); upd_evt = 1;
    @(negedge clk); upd_evt = 0;
    chk("R4 shadow loaded on update", cmp_eq, 1);
    wr(2'd1, 16'h0000);

    // R6 R10 R11 compare event, irq, dma
    cnt = 16'd50;
    wr(2'd0, 16'h0018);
    wr(2'd2, 16'd60);
    wr(2'd1, 16'h0000);
    rd(A(1), r); chk("R6 flag clear before match", r, 0);
    cnt = 16'd60;
    @(negedge clk);
    rd(A(1), r); chk("R6 flag set after match", r, 1);
    chk("R6 irq", irq, 1);
    chk("R11 dma pulse", dma_req, 1);
    @(negedge clk);
    chk("R11 dma one cycle", dma_req, 0);
    wr(2'd1, 16'h0003);
    rd(A(1), r); chk("R10 write one keeps flag", r, 1);
    wr(2'd1, 16'h0000);
    rd(A(1), r); chk("R10 write zero clears", r, 0);
    chk("R6 irq follows flag", irq, 0);

    // R7 capture latency and sample point, rising edge
    wr(2'd0, 16'h0009);
    wr(2'd1, 16'h0000);
    cycles(3);
    #1;
    chk("R5 quiet in capture eq", cmp_eq, 0);
    chk("R5 quiet in capture gt", cmp_gt, 0);
    @(negedge clk); sig_in = 1; cnt = 16'h0200;
    @(negedge clk); cnt = 16'h0201;
    @(negedge clk); cnt = 16'h0202;
    @(negedge clk); cnt = 16'h0203;
    rd(A(1), r); chk("R7 flag not yet", r, 0);
    @(negedge clk);
    rd(A(1), r); chk("R7 flag set", r, 1);
    rd(A(2), r); chk("R7 captured sample", r, 16'h0202);
    chk("R7 irq", irq, 1);

    // R8 rising mode ignores falling edge
    cnt = 16'h0250; sig_in = 0;
    cycles(6);
    rd(A(2), r); chk("R8 falling ignored", r, 16'h0202);
    rd(A(1), r); chk("R8 no overcapture", r, 1);

    // R9 overcapture
    cnt = 16'h0300; sig_in = 1;
    cycles(6);
    rd(A(1), r); chk("R9 overcapture flag", r, 3);
    rd(A(2), r); chk("R9 newer value kept", r, 16'h0300);

    // R8 falling edge mode
    wr(2'd0, 16'h000B);
    wr(2'd1, 16'h0000);
    cnt = 16'h0400; sig_in = 0;
    cycles(6);
    rd(A(1), r); chk("R8 falling flag", r, 1);
    rd(A(2), r); chk("R8 falling value", r, 16'h0400);
    wr(2'd1, 16'h0000);
    cnt = 16'h0500; sig_in = 1;
    cycles(6);
    rd(A(1), r); chk("R8 rising ignored flag", r, 0);
    rd(A(2), r); chk("R8 rising ignored value", r, 16'h0400);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [1:0] A(input int n);
    return n[1:0];
  endfunction
endmodule